// File: doc/BRIEF.md
# Reset Sequence Manager

This block merges three reset requests into one system reset and walks the chip out of reset in a fixed order. The requests are a low level on the external reset pin, an asserted low-voltage flag and a watchdog timeout. The pin input is qualified by a consecutive-sample filter, and every accepted request restarts a stretching counter. For as long as a request or its stretch is alive, the block stays in its active phase and pulls the pin low.

Once all requests are gone, the block keeps the pin low for a fixed stabilisation count. It then places the two reset-vector addresses on a fetch port, one per cycle, and finally lets the core run. When the PLL gate is enabled, the core is released only after the PLL reports ready. A cause register remembers which request started the reset until software clears it.

The pin read-back is ignored while the block itself pulls the pin. This stops the block's own pull-down from counting as a fresh external request.

Top module: `rst_seq_mgr`

## Requirements
- R1: A filtered pin event, a high `lvd_flag` or a high `wdog_tmo` sampled on a clock edge makes `core_rst` and `pin_pd` high after that same edge.
- R2: `pin_pd` is high for the whole active phase and the whole stabilisation phase. It is low during the vector fetch and after release. `core_rst` is high whenever `pin_pd` is high.
- R3: A pin event is accepted only after `pin_in` has been sampled low on 4 consecutive edges while `pin_pd` is low. A low lasting 3 samples has no effect. A 4-sample low makes `pin_pd` rise after the 5th edge counted from the first low sample.
- R4: The active phase lasts while any request is sampled and for 16 more edges after the last one. Counted from the cycle after the last sampled request, `pin_pd` stays high for 17 + 256 = 273 cycles.
- R5: The stabilisation phase lasts exactly 256 cycles. It is followed by exactly two cycles with `fetch_stb` high: `fetch_addr` is 16'hFFFE in the first and 16'hFFFF in the second. `fetch_addr` is 0 whenever `fetch_stb` is low.
- R6: A request sampled during the stabilisation or fetch phase returns the block to the active phase on the next cycle. From there the full 273-cycle `pin_pd` span and the fetch run again from the start.
- R7: With `pll_en` low, `core_rst` falls in the cycle right after the second fetch cycle.
- R8: With `pll_en` high, `core_rst` stays high after the second fetch cycle until `pll_ready` is sampled high. It falls in the cycle after that edge.
- R9: `cause` bit 0 records a pin event, bit 1 a low-voltage flag and bit 2 a watchdog timeout. A sampled `lvd_flag` sets `cause` to 3'b010 alone. The other events OR their bit in. Bits persist until a 1 in `cause_clr` clears them, and a set in the same cycle wins over a clear.
- R10: While `por` is high, `core_rst` and `pin_pd` are 1 and `fetch_stb` and `cause` are 0. After `por` falls, the power-up active phase behaves as one request in its last cycle: 273 cycles of `pin_pd`, then the fetch and the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, asynchronous, active high |
| pin_in | input | 1 | Sampled level of the reset pin (0 = low) |
| lvd_flag | input | 1 | Low-voltage detect flag, active high |
| wdog_tmo | input | 1 | Watchdog timeout, active high |
| pll_en | input | 1 | Gates core release on PLL ready |
| pll_ready | input | 1 | PLL startup complete |
| cause_clr | input | 3 | Write-one-to-clear strobe for `cause` |
| core_rst | output | 1 | Reset to the core, active high |
| pin_pd | output | 1 | Pull-down enable for the reset pin |
| fetch_stb | output | 1 | Vector fetch strobe |
| fetch_addr | output | 16 | Vector fetch address |
| cause | output | 3 | Latched reset cause flags |

## Verification
An internal request changes `core_rst`, `pin_pd` and `cause` one edge after it is sampled. A pin low changes them after the 5th sampling edge. From the cycle after the last request, `pin_pd` spans 273 cycles, `fetch_stb` the next two, and release follows one cycle later. A clear shows in `cause` one edge after its strobe.

The bench drives inputs on falling edges and advances its own cycle model on rising edges. It compares every output with that model on each falling edge, so each result is checked in exactly the cycle it is due. Directed sequences count the `pin_pd` span and then sample the fetch and release cycles one by one.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_HOLD   = 3'd1,
    ST_VEC_LO = 3'd2,
    ST_VEC_HI = 3'd3,
    ST_PLL    = 3'd4,
    ST_RUN    = 3'd5
  } rsm_state_e;

  localparam int CAUSE_W = 3;
  localparam int CZ_PIN  = 0;
  localparam int CZ_LVD  = 1;
  localparam int CZ_WDG  = 2;
endpackage

// File: rtl/rsm_pin_filter.sv
module rsm_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic por,
  input  logic pin_in,
  input  logic pulling,
  output logic ext_evt
);
  localparam int LW = $clog2(FILT_LEN + 1);
  localparam logic [LW-1:0] LAST = LW'(FILT_LEN - 1);
  localparam logic [LW-1:0] SAT  = LW'(FILT_LEN);

  logic [LW-1:0] lows;
  logic          low_seen;

  // a low only counts while the block itself is not pulling the pin
  assign low_seen = !pin_in && !pulling;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      lows    <= '0;
      ext_evt <= 1'b0;
    end else begin
      ext_evt <= low_seen && (lows == LAST);
      if (!low_seen)
        lows <= '0;
      else if (lows != SAT)
        lows <= lows + 1'b1;
    end
  end

  assert_evt_single_R3: assert property (@(posedge clk) disable iff (por)
    ext_evt |=> !ext_evt);
  assert_evt_low_R3: assert property (@(posedge clk) disable iff (por)
    ext_evt |-> $past(!pin_in));
endmodule

// File: rtl/rsm_pulse_gen.sv
module rsm_pulse_gen #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic por,
  input  logic trig,
  output logic busy
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_LEN);

  logic [PW-1:0] cnt;

  // power-up counts as one internal event
  always_ff @(posedge clk or posedge por) begin
    if (por)
      cnt <= PLOAD;
    else if (trig)
      cnt <= PLOAD;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  assert_stretch_R4: assert property (@(posedge clk) disable iff (por)
    $fell(busy) |-> !$past(trig));
endmodule

// File: rtl/rsm_cause.sv
module rsm_cause
  import rsm_pkg::*;
(
  input  logic               clk,
  input  logic               por,
  input  logic               ext_evt,
  input  logic               lvd,
  input  logic               wdg,
  input  logic [CAUSE_W-1:0] clr,
  output logic [CAUSE_W-1:0] cause
);
  logic [CAUSE_W-1:0] set_v;
  logic [CAUSE_W-1:0] lvd_only;

  always_comb begin
    set_v          = '0;
    set_v[CZ_PIN]  = ext_evt;
    set_v[CZ_WDG]  = wdg;
    lvd_only         = '0;
    lvd_only[CZ_LVD] = 1'b1;
  end

  always_ff @(posedge clk or posedge por) begin
    if (por)
      cause <= '0;
    else if (lvd)
      cause <= lvd_only;
    else
      cause <= (cause & ~clr) | set_v;
  end

  assert_lvd_alone_R9: assert property (@(posedge clk) disable iff (por)
    lvd |=> (cause == 3'b010));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (por)
    (!lvd && !ext_evt && !wdg && clr == '0) |=> $stable(cause));
endmodule

// File: rtl/rsm_seq.sv
module rsm_seq
  import rsm_pkg::*;
#(
  parameter int          DELAY_CYC = 256,
  parameter int          ADDR_W    = 16,
  parameter int unsigned VEC_ADDR  = 32'hFFFE
) (
  input  logic              clk,
  input  logic              por,
  input  logic              req,
  input  logic              pll_en,
  input  logic              pll_ready,
  output logic              core_rst,
  output logic              pin_pd,
  output logic              fetch_stb,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int DW = $clog2(DELAY_CYC);
  localparam logic [DW-1:0]     TERM  = DW'(DELAY_CYC - 1);
  localparam logic [ADDR_W-1:0] VEC_A = ADDR_W'(VEC_ADDR);
  localparam logic [ADDR_W-1:0] VEC_B = ADDR_W'(VEC_ADDR + 1);

  rsm_state_e    state, nxt;
  logic [DW-1:0] dcnt, dcnt_n;

  always_comb begin
    nxt    = state;
    dcnt_n = dcnt;
    if (req) begin
      nxt    = ST_ACTIVE;
      dcnt_n = '0;
    end else begin
      case (state)
        ST_ACTIVE: begin
          nxt    = ST_HOLD;
          dcnt_n = '0;
        end
        ST_HOLD: begin
          if (dcnt == TERM) nxt = ST_VEC_LO;
          else              dcnt_n = dcnt + 1'b1;
        end
        ST_VEC_LO: nxt = ST_VEC_HI;
        ST_VEC_HI: nxt = pll_en ? ST_PLL : ST_RUN;
        ST_PLL:    if (pll_ready) nxt = ST_RUN;
        ST_RUN:    nxt = ST_RUN;
        default:   nxt = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      state      <= ST_ACTIVE;
      dcnt       <= '0;
      core_rst   <= 1'b1;
      pin_pd     <= 1'b1;
      fetch_stb  <= 1'b0;
      fetch_addr <= '0;
    end else begin
      state      <= nxt;
      dcnt       <= dcnt_n;
      core_rst   <= (nxt != ST_RUN);
      pin_pd     <= (nxt == ST_ACTIVE) || (nxt == ST_HOLD);
      fetch_stb  <= (nxt == ST_VEC_LO) || (nxt == ST_VEC_HI);
      fetch_addr <= (nxt == ST_VEC_LO) ? VEC_A :
                    (nxt == ST_VEC_HI) ? VEC_B : '0;
    end
  end

  assert_pd_under_rst_R2: assert property (@(posedge clk) disable iff (por)
    pin_pd |-> core_rst);
  assert_fetch_order_R5: assert property (@(posedge clk) disable iff (por)
    (fetch_stb && fetch_addr == VEC_A && !req) |=> (fetch_stb && fetch_addr == VEC_B));
  assert_pll_hold_R8: assert property (@(posedge clk) disable iff (por)
    (pll_en && !pll_ready && core_rst && !pin_pd && !fetch_stb && !req) |=> core_rst);
endmodule

// File: rtl/rst_seq_mgr.sv
module rst_seq_mgr
  import rsm_pkg::*;
#(
  parameter int          FILT_LEN  = 4,
  parameter int          PULSE_LEN = 16,
  parameter int          DELAY_CYC = 256,
  parameter int          ADDR_W    = 16,
  parameter int unsigned VEC_ADDR  = 32'hFFFE
) (
  input  logic               clk,
  input  logic               por,
  input  logic               pin_in,
  input  logic               lvd_flag,
  input  logic               wdog_tmo,
  input  logic               pll_en,
  input  logic               pll_ready,
  input  logic [CAUSE_W-1:0] cause_clr,
  output logic               core_rst,
  output logic               pin_pd,
  output logic               fetch_stb,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic [CAUSE_W-1:0] cause
);
  logic ext_evt;
  logic trig;
  logic busy;
  logic req;

  rsm_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .por(por), .pin_in(pin_in), .pulling(pin_pd), .ext_evt(ext_evt)
  );

  assign trig = ext_evt | lvd_flag | wdog_tmo;

  rsm_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .por(por), .trig(trig), .busy(busy)
  );

  assign req = trig | busy;

  rsm_cause u_cause (
    .clk(clk), .por(por), .ext_evt(ext_evt), .lvd(lvd_flag), .wdg(wdog_tmo),
    .clr(cause_clr), .cause(cause)
  );

  rsm_seq #(.DELAY_CYC(DELAY_CYC), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_seq (
    .clk(clk), .por(por), .req(req), .pll_en(pll_en), .pll_ready(pll_ready),
    .core_rst(core_rst), .pin_pd(pin_pd), .fetch_stb(fetch_stb),
    .fetch_addr(fetch_addr)
  );

  assert_source_R1: assert property (@(posedge clk) disable iff (por)
    (lvd_flag || wdog_tmo) |=> (core_rst && pin_pd));
  assert_restart_R6: assert property (@(posedge clk) disable iff (por)
    req |=> (pin_pd && core_rst && !fetch_stb));
endmodule

// File: tb/test_rst_seq_mgr.sv
module test_rst_seq_mgr;
  localparam int S_ACT = 0, S_HOLD = 1, S_VLO = 2, S_VHI = 3, S_PLL = 4, S_RUN = 5;
  localparam int FL = 4, PL = 16, DL = 256;
  localparam int SPAN = PL + 1 + DL;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        por = 1'b1, ext_hold = 1'b0, lvd = 1'b0, wdg = 1'b0;
  logic        pll_en = 1'b0, pll_ready = 1'b0;
  logic [2:0]  clr = 3'b000;
  logic        pin_in, core_rst, pin_pd, fetch_stb;
  logic [15:0] fetch_addr;
  logic [2:0]  cause;

  assign pin_in = ~(ext_hold | pin_pd);

  rst_seq_mgr i_rst_seq_mgr (
    .clk(clk), .por(por), .pin_in(pin_in), .lvd_flag(lvd), .wdog_tmo(wdg),
    .pll_en(pll_en), .pll_ready(pll_ready), .cause_clr(clr),
    .core_rst(core_rst), .pin_pd(pin_pd), .fetch_stb(fetch_stb),
    .fetch_addr(fetch_addr), .cause(cause)
  );

  int checks = 0, fails = 0;

  // cycle model built from the requirements
  int       m_st = S_ACT, m_dc = 0, m_lows = 0, m_p = PL;
  bit       m_evt = 0;
  bit [2:0] m_cause = 3'b000;

  always @(posedge clk) begin
    if (por) begin
      m_st = S_ACT; m_dc = 0; m_lows = 0; m_p = PL; m_evt = 0; m_cause = 0;
    end else begin
      bit pd_m, low, n_evt, trig, busy, req;
      pd_m  = (m_st == S_ACT) || (m_st == S_HOLD);
      low   = ext_hold && !pd_m;
      n_evt = low && (m_lows == FL - 1);
      m_lows = !low ? 0 : ((m_lows == FL) ? FL : m_lows + 1);
      trig  = m_evt | lvd | wdg;
      busy  = (m_p != 0);
      req   = trig | busy;
      if (lvd) m_cause = 3'b010;
      else     m_cause = (m_cause & ~clr) | {wdg, 1'b0, m_evt};
      m_p = trig ? PL : (busy ? m_p - 1 : 0);
      if (req) begin m_st = S_ACT; m_dc = 0; end
      else case (m_st)
        S_ACT:  begin m_st = S_HOLD; m_dc = 0; end
        S_HOLD: if (m_dc == DL - 1) m_st = S_VLO; else m_dc = m_dc + 1;
        S_VLO:  m_st = S_VHI;
        S_VHI:  m_st = pll_en ? S_PLL : S_RUN;
        S_PLL:  if (pll_ready) m_st = S_RUN;
        default: ;
      endcase
      m_evt = n_evt;
    end
  end

  function automatic int exp_addr(int st);
    return (st == S_VLO) ? 32'hFFFE : ((st == S_VHI) ? 32'hFFFF : 0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R7 core_rst vs model", int'(core_rst), int'(m_st != S_RUN));
    chk("R2 pin_pd vs model", int'(pin_pd), int'((m_st == S_ACT) || (m_st == S_HOLD)));
    chk("R5 fetch_stb vs model", int'(fetch_stb), int'((m_st == S_VLO) || (m_st == S_VHI)));
    chk("R5 fetch_addr vs model", int'(fetch_addr), exp_addr(m_st));
    chk("R9 cause vs model", int'(cause), int'(m_cause));
  endtask

  task automatic count_pd(output int n);
    n = 0;
    while (pin_pd === 1'b1 && n < 2000) begin
      n++;
      step();
    end
  endtask

  // counted from the cycle after the last sampled request
  task automatic expect_tail(string tag, bit released);
    int n;
    count_pd(n);
    chk({tag, " pin_pd span"}, n, SPAN);
    chk("R5 first fetch addr", int'(fetch_addr), 32'hFFFE);
    chk("R5 first fetch strobe", int'(fetch_stb), 1);
    step();
    chk("R5 second fetch addr", int'(fetch_addr), 32'hFFFF);
    step();
    if (released) chk("R7 release after fetch", int'(core_rst), 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int r, ext_left, lvd_left;
    void'($urandom(32'd9271));
    repeat (3) step();
    chk("R10 core_rst in por", int'(core_rst), 1);
    chk("R10 pin_pd in por", int'(pin_pd), 1);
    chk("R10 fetch_stb in por", int'(fetch_stb), 0);
    chk("R10 cause in por", int'(cause), 0);
    por = 1'b0;
    expect_tail("R10", 1'b1);
    repeat (5) step();

    // R3: three-sample glitch is ignored
    ext_hold = 1'b1; repeat (3) step(); ext_hold = 1'b0;
    repeat (20) step();
    chk("R3 glitch core_rst", int'(core_rst), 0);
    chk("R3 glitch cause", int'(cause), 0);

    // R3/R1: four-sample low is accepted after the 5th edge
    ext_hold = 1'b1; repeat (4) step();
    chk("R3 not yet accepted", int'(core_rst), 0);
    ext_hold = 1'b0; step();
    chk("R1 pin reset core_rst", int'(core_rst), 1);
    chk("R3 pin reset pin_pd", int'(pin_pd), 1);
    chk("R9 pin cause", int'(cause), 3'b001);
    expect_tail("R4", 1'b1);
    clr = 3'b001; step(); clr = 3'b000;
    chk("R9 w1c clear", int'(cause), 0);

    // watchdog event
    wdg = 1'b1; step(); wdg = 1'b0;
    chk("R1 watchdog core_rst", int'(core_rst), 1);
    chk("R9 watchdog cause", int'(cause), 3'b100);
    expect_tail("R4", 1'b1);

    // LVD held with a coincident watchdog: LVD alone recorded
    lvd = 1'b1; wdg = 1'b1; step(); wdg = 1'b0;
    repeat (9) step();
    lvd = 1'b0;
    chk("R9 lvd priority", int'(cause), 3'b010);
    expect_tail("R4", 1'b1);

    // set wins over clear, then restart during stabilisation
    clr = 3'b111; wdg = 1'b1; step(); wdg = 1'b0; clr = 3'b000;
    chk("R9 set beats clear", int'(cause), 3'b100);
    repeat (150) step();
    chk("R6 still holding", int'(pin_pd), 1);
    wdg = 1'b1; step(); wdg = 1'b0;
    expect_tail("R6", 1'b1);

    // restart during the first fetch cycle
    wdg = 1'b1; step(); wdg = 1'b0;
    begin
      int n;
      count_pd(n);
      chk("R4 span before abort", n, SPAN);
    end
    wdg = 1'b1; step(); wdg = 1'b0;
    chk("R6 fetch aborted", int'(fetch_stb), 0);
    chk("R6 pin low again", int'(pin_pd), 1);
    expect_tail("R6", 1'b1);

    // PLL gate
    pll_en = 1'b1; pll_ready = 1'b0;
    wdg = 1'b1; step(); wdg = 1'b0;
    expect_tail("R8", 1'b0);
    chk("R8 held for pll", int'(core_rst), 1);
    repeat (20) step();
    chk("R8 still held", int'(core_rst), 1);
    pll_ready = 1'b1; step();
    chk("R8 released on ready", int'(core_rst), 0);
    pll_ready = 1'b0; pll_en = 1'b0;

    // random traffic against the model
    ext_left = 0; lvd_left = 0;
    for (int i = 0; i < 12000; i++) begin
      r = int'($urandom % 1000);
      ext_hold = (ext_left > 0);
      if (ext_left > 0) ext_left--;
      else if (r < 2) ext_left = 1 + int'($urandom % 8);
      lvd = (lvd_left > 0);
      if (lvd_left > 0) lvd_left--;
      else if (r == 5) lvd_left = 1 + int'($urandom % 6);
      wdg = (r == 7);
      if (r == 30) pll_en = ~pll_en;
      pll_ready = (($urandom % 8) == 0);
      clr = (r >= 40 && r < 50) ? 3'($urandom) : 3'b000;
      step();
    end
    ext_hold = 1'b0; lvd = 1'b0; wdg = 1'b0; clr = 3'b000;
    repeat (5) step();
    summary();
    $finish;
  end
endmodule